// File: doc/BRIEF.md
# Saturating DSP Arithmetic Unit

This execute unit performs signed DSP arithmetic in one clock cycle. It offers two kinds of operation. The first is a clamped 32-bit add or subtract. It can optionally double its second operand first, and that doubling stage clamps on its own. The second is a signed 16×16 multiply whose product is added, with wraparound, into a 64-bit accumulator. The caller supplies this accumulator as a high word and a low word.

A one-cycle pulse reports each clamping event. The surrounding core uses this pulse to set its sticky saturation flag, which this block never clears. A core-version input tells the unit which core it serves. When it is low, the core is the older one, and every request returns an undefined-instruction request in place of a result.

Top module: `sat_dsp_unit`

## Requirements
- R1: For a clamped operation, `op_code` bit 0 selects subtraction (`opnd_a - second`) when 1 and addition (`opnd_a + second`) when 0. The encodings are 00 add, 01 subtract, 10 doubled add, 11 doubled subtract.
- R2: When `op_code` bit 1 is 1, `opnd_b` is doubled before the add or subtract. If the doubling overflows, the doubled value is clamped to 0x7FFFFFFF (positive `opnd_b`) or 0x80000000 (negative `opnd_b`), and `sat_pulse` is raised. This happens even when the following add or subtract does not overflow.
- R3: Signed overflow of the add or subtract gives 0x7FFFFFFF when the true result is positive and 0x80000000 when it is negative, and raises `sat_pulse`.
- R4: A clamped operation in which neither stage overflows returns the exact two's-complement result with `sat_pulse` low.
- R5: In the multiply-accumulate (`kind_mac`=1), `hsel_a`=1 picks bits 31:16 of `opnd_a` and `hsel_a`=0 picks bits 15:0. `hsel_b` picks the half of `opnd_b` in the same way. Both chosen halves are sign-extended.
- R6: The signed product is added modulo 2^64 to {`acc_hi`,`acc_lo`}, and the sum is returned on {`mac_hi`,`mac_lo`}.
- R7: A multiply-accumulate never raises `sat_pulse`.
- R8: With `core_new`=0, an accepted request raises `undef_req` for one cycle, and `out_valid` and `sat_pulse` stay low.
- R9: Results, `out_valid`, `sat_pulse` and `undef_req` appear on the first clock edge after `in_valid`. A cycle with `in_valid` low leaves `out_valid`, `sat_pulse` and `undef_req` low in the next cycle.
- R10: While `rst` is high at a clock edge, every output is cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request accepted this cycle |
| kind_mac | input | 1 | 1 = long multiply-accumulate, 0 = clamped add/subtract |
| op_code | input | 2 | Bit 0 subtract, bit 1 double second operand |
| hsel_a | input | 1 | Halfword select for opnd_a (1 = upper) |
| hsel_b | input | 1 | Halfword select for opnd_b (1 = upper) |
| core_new | input | 1 | 1 = newer core executes, 0 = older core traps |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| acc_hi | input | 32 | Accumulator upper word |
| acc_lo | input | 32 | Accumulator lower word |
| out_valid | output | 1 | Result registers updated |
| sat_result | output | 32 | Clamped add/subtract result |
| mac_hi | output | 32 | Accumulated sum, upper word |
| mac_lo | output | 32 | Accumulated sum, lower word |
| sat_pulse | output | 1 | One-cycle clamp event |
| undef_req | output | 1 | One-cycle undefined-instruction request |

## Verification
Every output is registered once, so all results and pulses are due exactly one rising edge after the request is presented. The bench drives each request on a falling edge and samples on the next falling edge, after that single register stage has updated. It then drops `in_valid` and samples one more cycle to confirm the pulses have returned low. Reset is checked by sampling on a falling edge after a rising edge at which reset was held.

// File: rtl/dsp_pkg.sv
package dsp_pkg;

    localparam int DSP_W = 32;

    typedef enum logic [1:0] {
        OP_ADD  = 2'b00,
        OP_SUB  = 2'b01,
        OP_DADD = 2'b10,
        OP_DSUB = 2'b11
    } sat_op_e;

    typedef struct packed {
        logic             vld;
        logic             undef;
        logic             sat;
        logic [DSP_W-1:0] res;
        logic [DSP_W-1:0] hi;
        logic [DSP_W-1:0] lo;
    } dsp_out_t;

    function automatic logic op_is_sub(input logic [1:0] op);
        return op[0];
    endfunction

    function automatic logic op_is_dbl(input logic [1:0] op);
        return op[1];
    endfunction

endpackage

// File: rtl/dsp_dbl_stage.sv
module dsp_dbl_stage #(
    parameter int DW = dsp_pkg::DSP_W
) (
    input  logic          en,
    input  logic [DW-1:0] val,
    output logic [DW-1:0] dbl,
    output logic          ovf
);
    localparam logic [DW-1:0] POS_LIM = {1'b0, {(DW-1){1'b1}}};
    localparam logic [DW-1:0] NEG_LIM = {1'b1, {(DW-1){1'b0}}};

    always_comb begin
        ovf = en && (val[DW-1] != val[DW-2]);
        if (!en)
            dbl = val;
        else if (ovf)
            dbl = val[DW-1] ? NEG_LIM : POS_LIM;
        else
            dbl = {val[DW-2:0], 1'b0};
    end
endmodule

// File: rtl/dsp_addsub_stage.sv
module dsp_addsub_stage #(
    parameter int DW = dsp_pkg::DSP_W
) (
    input  logic          sub,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic [DW-1:0] res,
    output logic          ovf
);
    localparam logic [DW-1:0] POS_LIM = {1'b0, {(DW-1){1'b1}}};
    localparam logic [DW-1:0] NEG_LIM = {1'b1, {(DW-1){1'b0}}};

    logic [DW:0] ea, eb, sum;

    always_comb begin
        ea  = {a[DW-1], a};
        eb  = {b[DW-1], b};
        sum = sub ? (ea - eb) : (ea + eb);
        ovf = sum[DW] != sum[DW-1];
        if (ovf)
            res = sum[DW] ? NEG_LIM : POS_LIM;
        else
            res = sum[DW-1:0];
    end
endmodule

// File: rtl/dsp_mac_stage.sv
module dsp_mac_stage #(
    parameter int DW = dsp_pkg::DSP_W
) (
    input  logic          sel_a,
    input  logic          sel_b,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic [DW-1:0] acc_hi,
    input  logic [DW-1:0] acc_lo,
    output logic [DW-1:0] sum_hi,
    output logic [DW-1:0] sum_lo
);
    localparam int HW = DW / 2;
    localparam int AW = 2 * DW;

    logic signed [HW-1:0]   ha, hb;
    logic signed [2*HW-1:0] prod;
    logic [AW-1:0]          prod_ext, acc, total;

    always_comb begin
        ha       = sel_a ? a[DW-1:HW] : a[HW-1:0];
        hb       = sel_b ? b[DW-1:HW] : b[HW-1:0];
        prod     = ha * hb;
        prod_ext = {{(AW-2*HW){prod[2*HW-1]}}, prod};
        acc      = {acc_hi, acc_lo};
        total    = acc + prod_ext;
        sum_hi   = total[AW-1:DW];
        sum_lo   = total[DW-1:0];
    end
endmodule

// File: rtl/sat_dsp_unit.sv
module sat_dsp_unit #(
    parameter int DW = dsp_pkg::DSP_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic          kind_mac,
    input  logic [1:0]    op_code,
    input  logic          hsel_a,
    input  logic          hsel_b,
    input  logic          core_new,
    input  logic [DW-1:0] opnd_a,
    input  logic [DW-1:0] opnd_b,
    input  logic [DW-1:0] acc_hi,
    input  logic [DW-1:0] acc_lo,
    output logic          out_valid,
    output logic [DW-1:0] sat_result,
    output logic [DW-1:0] mac_hi,
    output logic [DW-1:0] mac_lo,
    output logic          sat_pulse,
    output logic          undef_req
);
    import dsp_pkg::*;

    localparam logic [DW-1:0] POS_LIM = {1'b0, {(DW-1){1'b1}}};
    localparam logic [DW-1:0] NEG_LIM = {1'b1, {(DW-1){1'b0}}};

    logic [DW-1:0] dbl_val, as_res, m_hi, m_lo;
    logic          dbl_ovf, as_ovf, exec;
    sat_op_e       op;
    dsp_out_t      q;

    assign op   = sat_op_e'(op_code);
    assign exec = in_valid && core_new;

    dsp_dbl_stage #(.DW(DW)) u_dbl (
        .en  (op_is_dbl(op)),
        .val (opnd_b),
        .dbl (dbl_val),
        .ovf (dbl_ovf)
    );

    dsp_addsub_stage #(.DW(DW)) u_addsub (
        .sub (op_is_sub(op)),
        .a   (opnd_a),
        .b   (dbl_val),
        .res (as_res),
        .ovf (as_ovf)
    );

    dsp_mac_stage #(.DW(DW)) u_mac (
        .sel_a  (hsel_a),
        .sel_b  (hsel_b),
        .a      (opnd_a),
        .b      (opnd_b),
        .acc_hi (acc_hi),
        .acc_lo (acc_lo),
        .sum_hi (m_hi),
        .sum_lo (m_lo)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q.vld   <= exec;
            q.undef <= in_valid && !core_new;
            q.sat   <= exec && !kind_mac && (dbl_ovf || as_ovf);
            if (exec) begin
                if (kind_mac) begin
                    q.res <= '0;
                    q.hi  <= m_hi;
                    q.lo  <= m_lo;
                end else begin
                    q.res <= as_res;
                    q.hi  <= '0;
                    q.lo  <= '0;
                end
            end
        end
    end

    assign out_valid  = q.vld;
    assign undef_req  = q.undef;
    assign sat_pulse  = q.sat;
    assign sat_result = q.res;
    assign mac_hi     = q.hi;
    assign mac_lo     = q.lo;

    // R9
    latency_chk: assert property (@(posedge clk) disable iff (rst)
        exec |=> out_valid);

    // R8
    old_core_trap_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !core_new) |=> (undef_req && !out_valid && !sat_pulse));

    // R7
    mac_no_sat_chk: assert property (@(posedge clk) disable iff (rst)
        (exec && kind_mac) |=> !sat_pulse);

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && !undef_req && !sat_pulse));

    // R3
    clamp_value_chk: assert property (@(posedge clk) disable iff (rst)
        (exec && !kind_mac && as_ovf) |=> (sat_result == POS_LIM || sat_result == NEG_LIM));

    // R2
    dbl_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (exec && !kind_mac && dbl_ovf) |=> sat_pulse);

endmodule

// File: tb/test_sat_dsp_unit.sv
module test_sat_dsp_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid, kind_mac, hsel_a, hsel_b, core_new;
    logic [1:0]  op_code;
    logic [31:0] opnd_a, opnd_b, acc_hi, acc_lo;
    logic        out_valid, sat_pulse, undef_req;
    logic [31:0] sat_result, mac_hi, mac_lo;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    sat_dsp_unit i_sat_dsp_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .kind_mac(kind_mac),
        .op_code(op_code), .hsel_a(hsel_a), .hsel_b(hsel_b), .core_new(core_new),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .acc_hi(acc_hi), .acc_lo(acc_lo),
        .out_valid(out_valid), .sat_result(sat_result), .mac_hi(mac_hi),
        .mac_lo(mac_lo), .sat_pulse(sat_pulse), .undef_req(undef_req)
    );

    // {op, a, b, expected result, expected pulse}
    localparam int NSAT = 10;
    localparam logic [98:0] SAT_VEC [NSAT] = '{
        {2'b00, 32'h00000001, 32'h00000002, 32'h00000003, 1'b0},
        {2'b00, 32'h7FFFFFFF, 32'h00000001, 32'h7FFFFFFF, 1'b1},
        {2'b01, 32'h80000000, 32'h00000001, 32'h80000000, 1'b1},
        {2'b01, 32'h00000005, 32'h00000007, 32'hFFFFFFFE, 1'b0},
        {2'b10, 32'h00000000, 32'h40000000, 32'h7FFFFFFF, 1'b1},
        {2'b10, 32'h00000010, 32'h00000003, 32'h00000016, 1'b0},
        {2'b11, 32'h00000000, 32'hC0000000, 32'h7FFFFFFF, 1'b1},
        {2'b11, 32'hFFFFFFFF, 32'hC0000000, 32'h7FFFFFFF, 1'b0},
        {2'b10, 32'h80000000, 32'h80000000, 32'h80000000, 1'b1},
        {2'b10, 32'hFFFFFFFF, 32'h40000000, 32'h7FFFFFFE, 1'b1}
    };

    // {hsel_a, hsel_b, a, b, acc_hi, acc_lo, exp_hi, exp_lo}
    localparam int NMAC = 6;
    localparam logic [193:0] MAC_VEC [NMAC] = '{
        {1'b0, 1'b0, 32'h00000003, 32'h00000004, 32'h0, 32'h0, 32'h00000000, 32'h0000000C},
        {1'b1, 1'b0, 32'hFFFF0000, 32'h00000005, 32'h0, 32'h0, 32'hFFFFFFFF, 32'hFFFFFFFB},
        {1'b0, 1'b1, 32'h00000002, 32'h80000000, 32'h0, 32'h00010000, 32'h00000000, 32'h00000000},
        {1'b1, 1'b1, 32'h7FFF0000, 32'h7FFF0000, 32'h0, 32'hFFFFFFFF, 32'h00000001, 32'h3FFF0000},
        {1'b0, 1'b0, 32'h00000001, 32'h00000001, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000000, 32'h00000000},
        {1'b0, 1'b0, 32'h00008000, 32'h00008000, 32'h7FFFFFFF, 32'hFFFFFFFF, 32'h80000000, 32'h3FFFFFFF}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        in_valid = 0; kind_mac = 0; op_code = 2'b00; hsel_a = 0; hsel_b = 0;
        core_new = 1; opnd_a = '0; opnd_b = '0; acc_hi = '0; acc_lo = '0;
    endtask

    // present one request on a falling edge, sample one cycle later
    task automatic issue();
        in_valid = 1;
        @(negedge clk);
        in_valid = 0;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        rst = 1;
        // dirty the inputs during reset: R10 says outputs still clear
        in_valid = 1; opnd_a = 32'h7FFFFFFF; opnd_b = 32'h1;
        repeat (3) @(negedge clk);
        chk("R10 out_valid", {63'd0, out_valid}, 64'd0);
        chk("R10 sat_pulse", {63'd0, sat_pulse}, 64'd0);
        chk("R10 undef_req", {63'd0, undef_req}, 64'd0);
        chk("R10 results", {sat_result, mac_lo}, 64'd0);
        chk("R10 mac_hi", {32'd0, mac_hi}, 64'd0);
        idle_inputs();
        rst = 0;
        @(negedge clk);

        // clamped add/subtract table: R1 R2 R3 R4
        for (int i = 0; i < NSAT; i++) begin
            kind_mac = 0;
            op_code  = SAT_VEC[i][98:97];
            opnd_a   = SAT_VEC[i][96:65];
            opnd_b   = SAT_VEC[i][64:33];
            issue();
            chk("R9 valid", {63'd0, out_valid}, 64'd1);
            chk("R1/R2/R3/R4 result", {32'd0, sat_result}, {32'd0, SAT_VEC[i][32:1]});
            chk("R2/R3/R4 pulse", {63'd0, sat_pulse}, {63'd0, SAT_VEC[i][0]});
            @(negedge clk);
            chk("R9 pulse drops", {62'd0, sat_pulse, out_valid}, 64'd0);
        end

        // multiply-accumulate table: R5 R6 R7
        for (int i = 0; i < NMAC; i++) begin
            kind_mac = 1;
            op_code  = 2'b11;
            hsel_a   = MAC_VEC[i][193];
            hsel_b   = MAC_VEC[i][192];
            opnd_a   = MAC_VEC[i][191:160];
            opnd_b   = MAC_VEC[i][159:128];
            acc_hi   = MAC_VEC[i][127:96];
            acc_lo   = MAC_VEC[i][95:64];
            issue();
            chk("R5/R6 sum", {mac_hi, mac_lo}, MAC_VEC[i][63:0]);
            chk("R7 no pulse", {63'd0, sat_pulse}, 64'd0);
        end

        // R8: older core, clamped operation that would overflow
        idle_inputs();
        core_new = 0; opnd_a = 32'h7FFFFFFF; opnd_b = 32'h1;
        issue();
        chk("R8 undef", {63'd0, undef_req}, 64'd1);
        chk("R8 no valid", {63'd0, out_valid}, 64'd0);
        chk("R8 no pulse", {63'd0, sat_pulse}, 64'd0);
        @(negedge clk);
        chk("R8 undef one cycle", {63'd0, undef_req}, 64'd0);

        // R8: older core, multiply-accumulate
        kind_mac = 1; opnd_a = 32'h3; opnd_b = 32'h3;
        issue();
        chk("R8 mac undef", {62'd0, undef_req, out_valid}, 64'd2);

        // R9: back-to-back requests, each result due one edge later
        idle_inputs();
        op_code = 2'b00; opnd_a = 32'd10; opnd_b = 32'd20;
        in_valid = 1;
        @(negedge clk);
        chk("R9 first", {32'd0, sat_result}, 64'd30);
        op_code = 2'b01; opnd_a = 32'd10; opnd_b = 32'd20;
        @(negedge clk);
        chk("R1 R9 second", {32'd0, sat_result}, {32'd0, 32'hFFFFFFF6});
        in_valid = 0;
        @(negedge clk);
        chk("R9 idle", {61'd0, out_valid, sat_pulse, undef_req}, 64'd0);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule